// File: doc/BRIEF.md
# Block Copy and Compare Sequencer

This block is the execution engine for two string-style instructions of an 8-bit processor core. The core hands it the contents of its source pointer (HL), destination pointer (DE), byte counter (BC), accumulator and flag byte, together with the second opcode byte. The engine then runs the whole operation on its own over a request/acknowledge memory port. When it finishes, the core takes back the updated pointers, counter and flags.

Two operations are accepted. The first is a repeated downward copy. Each pass reads the byte addressed by HL, writes it to the address in DE, and then steps all three pairs down by one. Passes continue until the counter has just reached zero. The second is a single upward compare step. It reads the byte at HL and subtracts it from the accumulator only to form flags, then moves HL up and BC down by one. The engine raises `busy` while it owns the memory port and gives a one-clock `done` pulse when it has finished.

Top module: `bcs_engine`

## Requirements
- R1: A `start` pulse while idle begins the repeated downward copy when `op_code` is B8h and the upward compare step when it is A1h. A `start` with any other code value is ignored: `busy` stays low, no memory request is made and the pointer outputs keep their values.
- R2: In every copy pass the engine first reads the byte at HL. It issues the write to DE only after that read has been acknowledged, and the byte written is the byte read.
- R3: After each copy pass HL, DE and BC are each one lower, with wrap-around modulo 65536.
- R4: The copy stops after the pass in which BC reaches zero. A copy started with BC = 0 makes 65536 passes and ends with HL and DE at their starting values.
- R5: When a copy completes, flag bits 4 (half carry), 2 (parity/overflow) and 1 (subtract) are cleared. Bits 7 (sign), 6 (zero), 5, 3 and 0 (carry) keep the values they had at start.
- R6: A compare step issues exactly one read, at HL, and no write.
- R7: After a compare step HL is one higher and BC one lower, both modulo 65536, and DE is unchanged.
- R8: For a compare step, with difference D = A − (HL) taken to 8 bits: bit 7 = D[7]; bit 6 = 1 exactly when A equals the byte; bit 4 = 1 when the low nibble of A is below the low nibble of the byte; bit 2 = 1 when BC is nonzero after its decrement; bit 1 = 1. Bits 5, 3 and 0 keep their start values.
- R9: `busy` is high from the clock after an accepted start until the final memory acknowledge. `done` is high for exactly one clock after that acknowledge, and `busy` is low at that time. A pending memory request keeps its address and direction until it is acknowledged.
- R10: After reset, `busy`, `done` and `mem_req` are low, and the pointer, counter and flag outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch request, sampled while idle |
| op_code | input | 8 | Second opcode byte selecting the operation |
| hl_in | input | 16 | Source pointer at launch |
| de_in | input | 16 | Destination pointer at launch |
| bc_in | input | 16 | Byte counter at launch |
| acc_in | input | 8 | Accumulator value for the compare |
| flags_in | input | 8 | Flag byte at launch |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |
| hl_out | output | 16 | Current source pointer |
| de_out | output | 16 | Current destination pointer |
| bc_out | output | 16 | Current byte counter |
| flags_out | output | 8 | Current flag byte |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with acknowledge |
| mem_ack | input | 1 | Memory acknowledge |

## Verification
The compare step is run with equal operands, with a byte larger than A (a negative difference with no nibble borrow and the counter reaching zero), and with a nibble borrow while HL and BC both wrap. Together these separate the zero, sign, half-borrow and parity results and show that carry is kept. The copy is run with several counts, acknowledge latencies of zero to three cycles and a source at address zero. This shows the read-then-write order, the byte carried between them and the pointer wrap. The copy is also run with a counter of zero, which checks the full 65536-pass case. An unrecognised code value is then shown to leave the outputs and the port idle.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

   localparam int          OPC_W    = 8;
   localparam logic [7:0]  OPC_COPY = 8'hB8;
   localparam logic [7:0]  OPC_CMP  = 8'hA1;

   localparam int FL_S  = 7;
   localparam int FL_Z  = 6;
   localparam int FL_H  = 4;
   localparam int FL_PV = 2;
   localparam int FL_N  = 1;
   localparam int FL_C  = 0;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RD   = 2'd1,
      ST_WR   = 2'd2
   } bcs_state_t;

   typedef enum logic {
      OP_COPY_DN = 1'b0,
      OP_CMP_UP  = 1'b1
   } bcs_op_t;

endpackage

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
   import bcs_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [OPC_W-1:0]    op_code,
   input  logic                mem_ack,
   input  logic                bc_last,
   output bcs_state_t          state,
   output logic                load,
   output logic                rd_capture,
   output logic                copy_step,
   output logic                copy_fin,
   output logic                cmp_step,
   output logic                busy,
   output logic                done
);

   bcs_op_t op_q;
   logic    code_ok;

   assign code_ok    = (op_code == OPC_COPY) || (op_code == OPC_CMP);
   assign load       = (state == ST_IDLE) && start && code_ok;
   assign rd_capture = (state == ST_RD) && mem_ack;
   assign cmp_step   = rd_capture && (op_q == OP_CMP_UP);
   assign copy_step  = (state == ST_WR) && mem_ack;
   assign copy_fin   = copy_step && bc_last;
   assign busy       = (state != ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         op_q  <= OP_COPY_DN;
         done  <= 1'b0;
      end else begin
         done <= cmp_step || copy_fin;
         unique case (state)
            ST_IDLE: begin
               if (load) begin
                  state <= ST_RD;
                  op_q  <= (op_code == OPC_CMP) ? OP_CMP_UP : OP_COPY_DN;
               end
            end
            ST_RD: begin
               if (mem_ack) state <= (op_q == OP_CMP_UP) ? ST_IDLE : ST_WR;
            end
            ST_WR: begin
               if (mem_ack) state <= bc_last ? ST_IDLE : ST_RD;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   assert_cmp_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && op_q == OP_CMP_UP) |-> state != ST_WR);
   assert_bad_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && start && !code_ok) |=> state == ST_IDLE);

endmodule

// File: rtl/bcs_mem_port.sv
module bcs_mem_port
   import bcs_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  bcs_state_t          state,
   input  logic                rd_capture,
   input  logic [ADDR_W-1:0]   src_ptr,
   input  logic [ADDR_W-1:0]   dst_ptr,
   input  logic [DATA_W-1:0]   mem_rdata,
   input  logic                mem_ack,
   output logic                mem_req,
   output logic                mem_we,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [DATA_W-1:0]   mem_wdata
);

   logic [DATA_W-1:0] hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n)          hold_q <= '0;
      else if (rd_capture) hold_q <= mem_rdata;
   end

   assign mem_req   = (state != ST_IDLE);
   assign mem_we    = (state == ST_WR);
   assign mem_addr  = mem_we ? dst_ptr : src_ptr;
   assign mem_wdata = hold_q;

   assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
   assert_write_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we) |-> $past(mem_req && mem_ack && !mem_we));

endmodule

// File: rtl/bcs_ptr_unit.sv
module bcs_ptr_unit #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic                copy_step,
   input  logic                cmp_step,
   input  logic [ADDR_W-1:0]   hl_in,
   input  logic [ADDR_W-1:0]   de_in,
   input  logic [CNT_W-1:0]    bc_in,
   output logic [ADDR_W-1:0]   hl,
   output logic [ADDR_W-1:0]   de,
   output logic [CNT_W-1:0]    bc,
   output logic                bc_last
);

   localparam int              N_PTR  = 2;
   localparam logic [ADDR_W-1:0] P_ONE = ADDR_W'(1);
   localparam logic [CNT_W-1:0]  C_ONE = CNT_W'(1);

   logic [ADDR_W-1:0] ptr_init [N_PTR];
   logic [ADDR_W-1:0] ptr_q    [N_PTR];

   assign ptr_init[0] = hl_in;
   assign ptr_init[1] = de_in;

   for (genvar i = 0; i < N_PTR; i++) begin : g_ptr
      localparam bit UP_ON_CMP = (i == 0);
      always_ff @(posedge clk) begin
         if (!rst_n)                      ptr_q[i] <= '0;
         else if (load)                   ptr_q[i] <= ptr_init[i];
         else if (copy_step)              ptr_q[i] <= ptr_q[i] - P_ONE;
         else if (cmp_step && UP_ON_CMP)  ptr_q[i] <= ptr_q[i] + P_ONE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                      bc <= '0;
      else if (load)                   bc <= bc_in;
      else if (copy_step || cmp_step)  bc <= bc - C_ONE;
   end

   assign hl      = ptr_q[0];
   assign de      = ptr_q[1];
   assign bc_last = (bc == C_ONE);

   assert_copy_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
      copy_step |=> (bc == $past(bc) - C_ONE) && (hl == $past(hl) - P_ONE)
                    && (de == $past(de) - P_ONE));
   assert_cmp_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_step |=> (hl == $past(hl) + P_ONE) && $stable(de));

endmodule

// File: rtl/bcs_flag_unit.sv
module bcs_flag_unit
   import bcs_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int HALF_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [DATA_W-1:0]  acc_in,
   input  logic [7:0]         flags_in,
   input  logic [DATA_W-1:0]  mem_byte,
   input  logic               cmp_step,
   input  logic               copy_fin,
   input  logic               bc_last,
   output logic [7:0]         flags
);

   logic [DATA_W-1:0] acc_q;
   logic [DATA_W-1:0] diff;
   logic              half_borrow;
   logic [7:0]        cmp_flags;
   logic [7:0]        copy_flags;

   always_comb begin
      diff        = acc_q - mem_byte;
      half_borrow = acc_q[HALF_W-1:0] < mem_byte[HALF_W-1:0];
      cmp_flags          = flags;
      cmp_flags[FL_S]    = diff[DATA_W-1];
      cmp_flags[FL_Z]    = (diff == '0);
      cmp_flags[FL_H]    = half_borrow;
      cmp_flags[FL_PV]   = !bc_last;
      cmp_flags[FL_N]    = 1'b1;
      copy_flags         = flags;
      copy_flags[FL_H]   = 1'b0;
      copy_flags[FL_PV]  = 1'b0;
      copy_flags[FL_N]   = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
         flags <= '0;
      end else if (load) begin
         acc_q <= acc_in;
         flags <= flags_in;
      end else if (cmp_step) begin
         flags <= cmp_flags;
      end else if (copy_fin) begin
         flags <= copy_flags;
      end
   end

   assert_cmp_n_keep_c_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_step |=> flags[FL_N] && (flags[FL_C] == $past(flags[FL_C])));
   assert_copy_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      copy_fin |=> !flags[FL_PV] && !flags[FL_N] && !flags[FL_H]
                   && (flags[FL_C] == $past(flags[FL_C])));

endmodule

// File: rtl/bcs_engine.sv
module bcs_engine
   import bcs_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16,
   parameter int DATA_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [7:0]         op_code,
   input  logic [ADDR_W-1:0]  hl_in,
   input  logic [ADDR_W-1:0]  de_in,
   input  logic [CNT_W-1:0]   bc_in,
   input  logic [DATA_W-1:0]  acc_in,
   input  logic [7:0]         flags_in,
   output logic               busy,
   output logic               done,
   output logic [ADDR_W-1:0]  hl_out,
   output logic [ADDR_W-1:0]  de_out,
   output logic [CNT_W-1:0]   bc_out,
   output logic [7:0]         flags_out,
   output logic               mem_req,
   output logic               mem_we,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [DATA_W-1:0]  mem_wdata,
   input  logic [DATA_W-1:0]  mem_rdata,
   input  logic               mem_ack
);

   localparam int HALF_W = DATA_W / 2;

   if (ADDR_W < 2) begin : g_bad_addr
      $error("bcs_engine: ADDR_W must be at least 2");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("bcs_engine: CNT_W must be at least 2");
   end
   if (DATA_W < 2 || (DATA_W % 2) != 0) begin : g_bad_data
      $error("bcs_engine: DATA_W must be even and at least 2");
   end

   bcs_state_t state;
   logic       load, rd_capture, copy_step, copy_fin, cmp_step, bc_last;

   bcs_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .op_code    (op_code),
      .mem_ack    (mem_ack),
      .bc_last    (bc_last),
      .state      (state),
      .load       (load),
      .rd_capture (rd_capture),
      .copy_step  (copy_step),
      .copy_fin   (copy_fin),
      .cmp_step   (cmp_step),
      .busy       (busy),
      .done       (done)
   );

   bcs_ptr_unit #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .copy_step (copy_step),
      .cmp_step  (cmp_step),
      .hl_in     (hl_in),
      .de_in     (de_in),
      .bc_in     (bc_in),
      .hl        (hl_out),
      .de        (de_out),
      .bc        (bc_out),
      .bc_last   (bc_last)
   );

   bcs_mem_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .state      (state),
      .rd_capture (rd_capture),
      .src_ptr    (hl_out),
      .dst_ptr    (de_out),
      .mem_rdata  (mem_rdata),
      .mem_ack    (mem_ack),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata)
   );

   bcs_flag_unit #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .acc_in   (acc_in),
      .flags_in (flags_in),
      .mem_byte (mem_rdata),
      .cmp_step (cmp_step),
      .copy_fin (copy_fin),
      .bc_last  (bc_last),
      .flags    (flags_out)
   );

   assert_busy_after_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && (op_code == OPC_COPY || op_code == OPC_CMP)) |=> busy);
   assert_reset_quiet_R10: assert property (@(posedge clk)
      !rst_n |=> (!busy && !done && !mem_req));

endmodule

// File: tb/tb_bcs_engine.sv
module tb_bcs_engine;

   typedef struct packed {
      logic [7:0]  op;
      logic [15:0] hl;
      logic [15:0] de;
      logic [15:0] bc;
      logic [7:0]  acc;
      logic [7:0]  fin;
      logic [7:0]  mbyte;
      logic [3:0]  lat;
      logic [15:0] ehl;
      logic [15:0] ede;
      logic [15:0] ebc;
      logic [7:0]  efl;
   } vec_t;

   localparam int NV = 5;
   localparam vec_t VECS [NV] = '{
      '{8'hA1, 16'h0100, 16'h0AAA, 16'h0005, 8'h42, 8'h00, 8'h42, 4'd0,
        16'h0101, 16'h0AAA, 16'h0004, 8'h46},
      '{8'hA1, 16'h0120, 16'h1234, 16'h0001, 8'h10, 8'h01, 8'h20, 4'd2,
        16'h0121, 16'h1234, 16'h0000, 8'h83},
      '{8'hA1, 16'hFFFF, 16'h0000, 16'h0000, 8'h30, 8'h28, 8'h01, 4'd1,
        16'h0000, 16'h0000, 16'hFFFF, 8'h3E},
      '{8'hB8, 16'h0210, 16'h0310, 16'h0003, 8'h00, 8'hD5, 8'h00, 4'd1,
        16'h020D, 16'h030D, 16'h0000, 8'hC1},
      '{8'hB8, 16'h0000, 16'h0800, 16'h0001, 8'h77, 8'h06, 8'h00, 4'd3,
        16'hFFFF, 16'h07FF, 16'h0000, 8'h00}
   };

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n, start;
   logic [7:0]  op_code, acc_in, flags_in;
   logic [15:0] hl_in, de_in, bc_in;
   logic        busy, done, mem_req, mem_we;
   logic [15:0] hl_out, de_out, bc_out, mem_addr;
   logic [7:0]  flags_out, mem_wdata;
   logic [7:0]  mem_rdata = 8'h00;
   logic        mem_ack = 1'b0;

   bcs_engine dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
      .hl_in(hl_in), .de_in(de_in), .bc_in(bc_in), .acc_in(acc_in),
      .flags_in(flags_in), .busy(busy), .done(done), .hl_out(hl_out),
      .de_out(de_out), .bc_out(bc_out), .flags_out(flags_out),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
   );

   logic [7:0]  mem [4096];
   int          lat = 0;
   int          wcnt = 0;
   int          n_rd = 0, n_wr = 0, bad_order = 0, bad_data = 0;
   logic        last_was_rd = 1'b0;
   logic [7:0]  last_byte = 8'h00;
   logic        fill = 1'b0, pl_en = 1'b0;
   logic [11:0] pl_addr = '0;
   logic [7:0]  pl_data = '0;
   int          n_chk = 0, n_bad = 0;

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 7 + 3) & 255);
   endfunction

   always @(negedge clk) begin
      if (mem_req && wcnt >= lat) begin
         mem_ack   <= 1'b1;
         mem_rdata <= mem[mem_addr[11:0]];
      end else begin
         mem_ack   <= 1'b0;
      end
   end

   always @(posedge clk) begin
      if (fill) begin
         for (int i = 0; i < 4096; i++) mem[i] <= pat(i);
      end else if (pl_en) begin
         mem[pl_addr] <= pl_data;
      end
      if (mem_req && mem_ack) begin
         wcnt <= 0;
         if (mem_we) begin
            mem[mem_addr[11:0]] <= mem_wdata;
            n_wr <= n_wr + 1;
            if (!last_was_rd) bad_order <= bad_order + 1;
            if (mem_wdata !== last_byte) bad_data <= bad_data + 1;
            last_was_rd <= 1'b0;
         end else begin
            n_rd <= n_rd + 1;
            last_byte <= mem_rdata;
            last_was_rd <= 1'b1;
         end
      end else if (mem_req) begin
         wcnt <= wcnt + 1;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic preload(input logic [11:0] a, input logic [7:0] d);
      @(negedge clk);
      pl_addr = a; pl_data = d; pl_en = 1'b1;
      @(negedge clk);
      pl_en = 1'b0;
   endtask

   int rd0, wr0, bo0, bd0;

   task automatic run_op(input vec_t v);
      int cyc;
      @(negedge clk);
      lat = int'(v.lat);
      op_code = v.op; hl_in = v.hl; de_in = v.de; bc_in = v.bc;
      acc_in = v.acc; flags_in = v.fin;
      rd0 = n_rd; wr0 = n_wr; bo0 = bad_order; bd0 = bad_data;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R9 busy after start", 32'(busy), 32'd1);
      cyc = 0;
      while (!done && cyc < 140000) begin
         @(negedge clk);
         cyc++;
      end
      chk("R9 done seen", 32'(done), 32'd1);
      chk("R9 busy low with done", 32'(busy), 32'd0);
      @(negedge clk);
      chk("R9 done one cycle", 32'(done), 32'd0);
   endtask

   initial begin
      rst_n = 1'b0; start = 1'b0; op_code = 8'h00;
      hl_in = '0; de_in = '0; bc_in = '0; acc_in = '0; flags_in = '0;
      fill = 1'b1;
      repeat (3) @(negedge clk);
      fill = 1'b0;
      chk("R10 busy", 32'(busy), 32'd0);
      chk("R10 done", 32'(done), 32'd0);
      chk("R10 mem_req", 32'(mem_req), 32'd0);
      chk("R10 hl", 32'(hl_out), 32'd0);
      chk("R10 bc", 32'(bc_out), 32'd0);
      chk("R10 flags", 32'(flags_out), 32'd0);
      rst_n = 1'b1;

      for (int k = 0; k < NV; k++) begin
         vec_t v;
         bit   is_cmp;
         v = VECS[k];
         is_cmp = (v.op == 8'hA1);
         if (is_cmp) preload(v.hl[11:0], v.mbyte);
         run_op(v);
         if (is_cmp) begin
            chk("R7 hl", 32'(hl_out), 32'(v.ehl));
            chk("R7 de", 32'(de_out), 32'(v.ede));
            chk("R7 bc", 32'(bc_out), 32'(v.ebc));
            chk("R8 flags", 32'(flags_out), 32'(v.efl));
            chk("R6 reads", 32'(n_rd - rd0), 32'd1);
            chk("R6 writes", 32'(n_wr - wr0), 32'd0);
         end else begin
            chk("R3 hl", 32'(hl_out), 32'(v.ehl));
            chk("R3 de", 32'(de_out), 32'(v.ede));
            chk("R4 bc", 32'(bc_out), 32'(v.ebc));
            chk("R5 flags", 32'(flags_out), 32'(v.efl));
            chk("R4 passes", 32'(n_wr - wr0), 32'(v.bc));
            chk("R2 order", 32'(bad_order - bo0), 32'd0);
            chk("R2 data", 32'(bad_data - bd0), 32'd0);
            for (int j = 0; j < int'(v.bc); j++) begin
               logic [15:0] s, d;
               s = v.hl - 16'(j);
               d = v.de - 16'(j);
               chk("R2 copied byte", 32'(mem[d[11:0]]), 32'(pat(int'(s[11:0]))));
            end
         end
      end

      // R1: unknown code value ignored
      @(negedge clk);
      op_code = 8'hB0; hl_in = 16'h5555; de_in = 16'h6666; bc_in = 16'h0004;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (2) @(negedge clk);
      chk("R1 busy stays low", 32'(busy), 32'd0);
      chk("R1 no request", 32'(mem_req), 32'd0);
      chk("R1 hl unchanged", 32'(hl_out), 32'(VECS[NV-1].ehl));
      chk("R1 de unchanged", 32'(de_out), 32'(VECS[NV-1].ede));

      // R4: counter zero at start gives 65536 passes
      begin
         vec_t w;
         w = '{8'hB8, 16'h0FFF, 16'h2FFF, 16'h0000, 8'h00, 8'h45, 8'h00, 4'd0,
               16'h0FFF, 16'h2FFF, 16'h0000, 8'h41};
         run_op(w);
         chk("R4 wrap passes", 32'(n_wr - wr0), 32'd65536);
         chk("R4 wrap hl", 32'(hl_out), 32'(w.ehl));
         chk("R4 wrap de", 32'(de_out), 32'(w.ede));
         chk("R4 wrap bc", 32'(bc_out), 32'(w.ebc));
         chk("R5 wrap flags", 32'(flags_out), 32'(w.efl));
         chk("R2 wrap order", 32'(bad_order - bo0), 32'd0);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (195000) @(posedge clk);
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad + 1);
      $finish;
   end

endmodule